// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the column addresses of that burst. The request carries a start column, a 3-bit length code, an ordering bit and a write-single override. After the start strobe, the block puts out one column address per clock. A valid flag marks each address, and a last flag marks the final word of a finite burst.

Addresses stay inside the aligned group of columns whose size is the burst length. They are ordered either by counting upward with wrap-around or by XOR-ing the low start bits with a word counter. A whole-row code keeps the burst running, wrapping at the column count, until a terminate input stops it. A separate mode bit turns every write into a single-location access.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is high, and on the first cycle after it, valid_o and last_o are 0 and col_o is 0.
- R2: A start_i sampled on a clock edge makes valid_o 1 on that same edge, with col_o equal to start_col_i. Every later word follows one per clock.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 words. last_o is 1 only on the final word, and valid_o is 0 on the cycle after it.
- R4: With ordering bit interleave_i = 0 (sequential), addresses step upward and wrap to the start of the aligned group. Length 4 from column 5 gives 5, 6, 7, 4.
- R5: With interleave_i = 1, each address is the start column with its low log2(length) bits XOR-ed by the word index. Length 4 from column 5 gives 5, 4, 7, 6.
- R6: A start column at the beginning of an aligned group gives ascending order under both settings of interleave_i. Length 8 from column 8 gives 8..15.
- R7: For lengths 1 and 2, interleave_i does not change the address order.
- R8: Code 3'b111 gives a whole-row burst. It counts upward modulo the column count (2**COL_W), always in sequential order, never raises last_o, and continues until terminated.
- R9: Reserved codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R10: When is_write_i and write_single_i are both 1 at start, the burst is one word whatever the code. A read, or a write with write_single_i = 0, follows the code.
- R11: term_i high on an edge during a burst, without start_i, makes valid_o and last_o 0 on that edge.
- R12: start_i during a running burst abandons it and begins the new burst at once. start_i takes priority over term_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst with the fields below |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 sequential order, 1 XOR order |
| is_write_i | input | 1 | The burst is a write |
| write_single_i | input | 1 | Force writes to a single location |
| term_i | input | 1 | Stop the current burst |
| col_o | output | COL_W | Column address of the current word |
| valid_o | output | 1 | col_o holds a burst word |
| last_o | output | 1 | Final word of a finite burst |

## Verification
A vector table drives each length code from unaligned, aligned and top-of-group start columns under both orderings. Comparing the two orderings from an unaligned start separates the wrap-add from the XOR. Aligned starts and lengths 1 and 2 confirm that the two orderings agree where they must. Reserved codes and write-single combinations show whether the length override keys on both bits together. Directed runs cover the whole-row burst crossing the top column, terminate in the middle of a burst, and a restart that overrides terminate.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_ROW   = 3'b111
  } bl_code_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code_i,
  input  logic             single_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_row_o
);
  import colgen_pkg::*;

  // Mask = burst length - 1; whole row uses all ones
  always_comb begin
    mask_o     = '0;
    full_row_o = 1'b0;
    case (len_code_i)
      BL_TWO:   mask_o = COL_W'(1);
      BL_FOUR:  mask_o = COL_W'(3);
      BL_EIGHT: mask_o = COL_W'(7);
      BL_ROW: begin
        mask_o     = '1;
        full_row_o = 1'b1;
      end
      default:  mask_o = '0; // one word, reserved codes included (R9)
    endcase
    if (single_i) begin     // R10 override
      mask_o     = '0;
      full_row_o = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_addr_form.sv
module colgen_addr_form #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] step_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_mode_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low_sum, low_xor, low_sel;

  assign low_sum = (start_col_i & mask_i) + step_i;
  assign low_xor = start_col_i ^ step_i;
  assign low_sel = xor_mode_i ? low_xor : low_sum;
  assign col_o   = (start_col_i & ~mask_i) | (low_sel & mask_i);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             is_write_i,
  input  logic             write_single_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] mask_d, mask_q, start_q, cnt_q, cnt_nx, addr_nx;
  logic             full_d, full_q, ilv_q;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .single_i   (is_write_i & write_single_i),
    .mask_o     (mask_d),
    .full_row_o (full_d)
  );

  assign cnt_nx = cnt_q + 1'b1;

  colgen_addr_form #(.COL_W(COL_W)) u_addr (
    .start_col_i (start_q),
    .step_i      (cnt_nx),
    .mask_i      (mask_q),
    .xor_mode_i  (ilv_q & ~full_q),
    .col_o       (addr_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      cnt_q   <= '0;
      mask_q  <= '0;
      start_q <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (start_i) begin
      start_q <= start_col_i;
      mask_q  <= mask_d;
      full_q  <= full_d;
      ilv_q   <= interleave_i;
      cnt_q   <= '0;
      col_o   <= start_col_i;
      valid_o <= 1'b1;
      last_o  <= !full_d && (mask_d == '0);
    end else if (valid_o && !term_i && !last_o) begin
      cnt_q   <= cnt_nx;
      col_o   <= addr_nx;
      last_o  <= !full_q && (cnt_nx == mask_q);
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

  a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
  a_r3_stop_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);
  a_r11_term_stops: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> (!valid_o && !last_o));
  a_r8_row_never_last: assert property (@(posedge clk) disable iff (rst)
    (valid_o && full_q) |-> !last_o);
  a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !term_i && !start_i && (!ilv_q || full_q)) |=>
      (((col_o - $past(col_o)) & $past(mask_q)) == COL_W'(1)));
  a_r4_group_kept: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !term_i && !start_i) |=>
      ((col_o & ~$past(mask_q)) == ($past(col_o) & ~$past(mask_q))));
endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;
  localparam int COL_W = 8;
  localparam int NV = 14;
  // [15:8] start col, [7:5] code, [4] interleave, [3] write, [2] write_single
  localparam logic [15:0] VEC [NV] = '{
    {8'd5,   3'b010, 1'b0, 1'b0, 1'b0, 2'b0},  // R4
    {8'd5,   3'b010, 1'b1, 1'b0, 1'b0, 2'b0},  // R5
    {8'd8,   3'b011, 1'b0, 1'b0, 1'b0, 2'b0},  // R6
    {8'd8,   3'b011, 1'b1, 1'b0, 1'b0, 2'b0},  // R6
    {8'd45,  3'b011, 1'b1, 1'b0, 1'b0, 2'b0},  // R3 R5
    {8'd46,  3'b011, 1'b0, 1'b0, 1'b0, 2'b0},  // R3 R4
    {8'd9,   3'b001, 1'b0, 1'b0, 1'b0, 2'b0},  // R7
    {8'd9,   3'b001, 1'b1, 1'b0, 1'b0, 2'b0},  // R7
    {8'd77,  3'b000, 1'b1, 1'b0, 1'b0, 2'b0},  // R3 R7
    {8'd6,   3'b100, 1'b0, 1'b0, 1'b0, 2'b0},  // R9
    {8'd6,   3'b110, 1'b1, 1'b0, 1'b0, 2'b0},  // R9
    {8'd13,  3'b011, 1'b0, 1'b1, 1'b1, 2'b0},  // R10 forced single
    {8'd13,  3'b011, 1'b0, 1'b0, 1'b1, 2'b0},  // R10 read unaffected
    {8'd255, 3'b010, 1'b0, 1'b1, 1'b0, 2'b0}   // R10 write normal
  };

  logic clk = 0, rst = 1, start_i = 0, interleave_i = 0;
  logic is_write_i = 0, write_single_i = 0, term_i = 0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i),
    .is_write_i(is_write_i), .write_single_i(write_single_i),
    .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] code, input logic wr, input logic ws);
    if (wr && ws) return 1;
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int len, input logic ilv, input int k);
    int base = s - (s % len);
    int off = s % len;
    if (ilv) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  // issue start at a negedge; first word is visible at the following negedge
  task automatic launch(input logic [7:0] c, input logic [2:0] code, input logic ilv,
                        input logic wr, input logic ws);
    start_col_i = c; len_code_i = code; interleave_i = ilv;
    is_write_i = wr; write_single_i = ws; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 last in reset", last_o, 0);
    chk("R1 col in reset", col_o, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [15:0] e = VEC[v];
      int len = exp_len(e[7:5], e[3], e[2]);
      launch(e[15:8], e[7:5], e[4], e[3], e[2]);
      for (int k = 0; k < len; k++) begin
        chk("R2 R3 valid", valid_o, 1);
        chk("R4 R5 R6 R7 R9 R10 col", col_o, exp_col(e[15:8], len, e[4], k));
        chk("R3 last", last_o, (k == len - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R3 idle after burst", valid_o, 0);
    end

    // literal orders
    launch(8'd5, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R4 w0", col_o, 5); @(negedge clk); chk("R4 w1", col_o, 6);
    @(negedge clk); chk("R4 w2", col_o, 7); @(negedge clk); chk("R4 w3", col_o, 4);
    @(negedge clk);
    launch(8'd5, 3'b010, 1'b1, 1'b0, 1'b0);
    chk("R5 w0", col_o, 5); @(negedge clk); chk("R5 w1", col_o, 4);
    @(negedge clk); chk("R5 w2", col_o, 7); @(negedge clk); chk("R5 w3", col_o, 6);
    @(negedge clk);

    // whole row across the top column, interleave ignored
    launch(8'd253, 3'b111, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      chk("R8 row valid", valid_o, 1);
      chk("R8 row col", col_o, (253 + k) % 256);
      chk("R8 row last", last_o, 0);
      @(negedge clk);
    end
    term_i = 1;
    @(negedge clk);
    term_i = 0;
    chk("R11 row terminated valid", valid_o, 0);
    chk("R11 row terminated last", last_o, 0);
    @(negedge clk);
    chk("R11 stays idle", valid_o, 0);

    // terminate mid finite burst
    launch(8'd16, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 second word", col_o, 17);
    term_i = 1;
    @(negedge clk);
    term_i = 0;
    chk("R11 finite terminated", valid_o, 0);

    // restart mid burst, start wins over term
    launch(8'd32, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    term_i = 1;
    launch(8'd21, 3'b001, 1'b0, 1'b0, 1'b0);
    term_i = 0;
    chk("R12 restart valid", valid_o, 1);
    chk("R12 restart col", col_o, 21);
    @(negedge clk);
    chk("R12 restart second", col_o, 20);
    chk("R12 restart last", last_o, 1);
    @(negedge clk);
    chk("R12 restart done", valid_o, 0);

    // reset during burst
    launch(8'd40, 3'b011, 1'b0, 1'b0, 1'b0);
    rst = 1;
    @(negedge clk);
    chk("R1 reset aborts", valid_o, 0);
    chk("R1 reset col", col_o, 0);
    rst = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule